// File: doc/BRIEF.md
# Random Number FIFO Peripheral

A 32-bit register-mapped random number source. While its generator is enabled, it fills an on-chip byte FIFO from a built-in 32-bit LFSR that stands in for the entropy source. Software drains the FIFO one 32-bit word at a time through a data register. It watches the fill level through a count register.

A running total of generated bits gates the filling. Each byte adds eight to this total, and no byte is stored once the total would reach the software threshold. Writing the threshold also reloads the total. Turning the generator on reloads the total with a fixed warm-up value.

Four interrupt sources are held in a status register and cleared by writing 1. A level interrupt is raised whenever an enabled status bit is set. A soft reset clears the block and latches the startup-complete status bit.

Register access is one request per cycle. A read returns its data registered on the next cycle.

Top module: `rng_fifo_periph`

## Requirements
- R1: After reset, the status register (0x18) reads 0x0002_0000 (bit 17 set). Control (0x00), bit count (0x0C), threshold (0x10), interrupt enable (0x1C) and FIFO count (0x24) read zero, and `irq` is low.
- R2: A read request returns its data on `rsp_rdata` with `rsp_valid` high on the following cycle. Reads of 0x04, 0x08, offsets outside the implemented words (including 0x14, 0x28 and above) and offsets that are not multiples of four return zero. Writes to those offsets change nothing.
- R3: Control keeps bit 0 (generator on) and bits 20:13 (stored divider); all other bits read zero. A write that takes bit 0 from 0 to 1 loads the bit count with 17.
- R4: In each cycle with the generator on and no write request, one LFSR byte is stored if the FIFO holds fewer than 128 bytes and (bit count + 8) < threshold, using unsigned 33-bit arithmetic; each stored byte adds 8 to the bit count. With the generator off, nothing is stored and nothing is cleared.
- R5: Writing the threshold register (0x10) stores the value and loads the bit count with value + 1.
- R6: The FIFO count register reads bits 7:0 = stored bytes / 4 (rounded down) and bits 15:8 = FIFO threshold. A write replaces only the FIFO threshold.
- R7: Reading the data register (0x20) removes min(stored, 4) bytes and returns them little-endian, with the oldest byte in bits 7:0 and missing bytes as zero. The stored bytes are the low 8 bits of an LFSR that starts at SEED and, on each stored byte, becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R8: Status bit 0 is set when, after a byte is stored, the occupancy at the end of that cycle exceeds the FIFO threshold.
- R9: Status and enable implement bits 0, 5, 17 and 30 only. Writing the status register clears each bit written as 1. The enable register is written directly. `irq` is high exactly when (status AND enable) is nonzero, and follows a register change on the next cycle.
- R10: Writing 0x04 with bit 0 = 1 clears every register and empties the FIFO, leaving only status bit 17 set. Writing 0x04 with bit 0 = 0, or writing 0x08, has no effect.
- R11: A data read and a stored byte in the same cycle are both applied: the new occupancy is old − popped + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Read data is due one cycle after the edge that accepts the read. It reflects the register state before that edge, including any bytes popped by the read itself. Stored bytes, counter loads, status changes and the interrupt level are all registered, so each is due on the cycle after its cause.

The bench drives a request at a falling edge and updates its reference model as of the next rising edge. It compares the read data and `irq` at the falling edge that follows, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/rng_fifo_periph.sv
module rng_fifo_periph #(
  parameter int          DEPTH = 128,
  parameter logic [31:0] SEED  = 32'hACE1_2468,
  parameter logic [31:0] WARM  = 32'd17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq
);
  localparam int          PW        = $clog2(DEPTH);
  localparam int          OW        = PW + 1;
  localparam logic [31:0] CTRL_MASK = 32'h001F_E001;
  localparam logic [31:0] STAT_MASK = 32'h4002_0021;
  localparam logic [31:0] STARTUP   = 32'h0002_0000;

  logic [31:0] ctrl_q, bcnt_q, thr_q, stat_q, ien_q, lfsr_q;
  logic [7:0]  fthr_q;
  logic [OW-1:0] occ_q, occ_nx;
  logic [PW-1:0] wp_q, rp_q;
  logic [7:0]  mem [DEPTH];
  logic [2:0]  avail, popn;
  logic [31:0] pop_word, rdat;

  wire wr_any = req_valid && req_write;
  wire rd_req = req_valid && !req_write;
  wire rd_pop = rd_req && req_addr == 8'h20;
  wire full   = occ_q == OW'(DEPTH);
  wire room   = ({1'b0, bcnt_q} + 33'd8) < {1'b0, thr_q};
  wire push   = ctrl_q[0] && !wr_any && !full && room;
  wire [31:0] lfsr_nx = {lfsr_q[30:0], lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};

  assign avail  = (occ_q >= OW'(4)) ? 3'd4 : occ_q[2:0];
  assign popn   = rd_pop ? avail : 3'd0;
  assign occ_nx = occ_q - OW'(popn) + OW'(push);
  assign irq    = |(stat_q & ien_q);

  always_comb begin
    for (int i = 0; i < 4; i++)
      pop_word[8*i +: 8] = (3'(i) < avail) ? mem[rp_q + PW'(i)] : 8'h00;
  end

  always_comb begin
    case (req_addr)
      8'h00:   rdat = ctrl_q;
      8'h0C:   rdat = bcnt_q;
      8'h10:   rdat = thr_q;
      8'h18:   rdat = stat_q;
      8'h1C:   rdat = ien_q;
      8'h20:   rdat = pop_word;
      8'h24:   rdat = {16'h0, fthr_q, 8'(occ_q >> 2)};
      default: rdat = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= lfsr_q[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; bcnt_q <= '0; thr_q <= '0; ien_q <= '0;
      stat_q <= STARTUP; fthr_q <= '0; occ_q <= '0;
      wp_q <= '0; rp_q <= '0; lfsr_q <= SEED;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rdat;
      rp_q  <= rp_q + PW'(popn);
      occ_q <= occ_nx;
      if (push) begin
        wp_q   <= wp_q + 1'b1;
        lfsr_q <= lfsr_nx;
        bcnt_q <= bcnt_q + 32'd8;
        if (32'(occ_nx) > 32'(fthr_q)) stat_q[0] <= 1'b1;
      end
      if (wr_any) begin
        case (req_addr)
          8'h00: begin
            ctrl_q <= req_wdata & CTRL_MASK;
            if (!ctrl_q[0] && req_wdata[0]) bcnt_q <= WARM;
          end
          8'h04: if (req_wdata[0]) begin
            ctrl_q <= '0; bcnt_q <= '0; thr_q <= '0; ien_q <= '0;
            stat_q <= STARTUP; fthr_q <= '0; occ_q <= '0;
            wp_q <= '0; rp_q <= '0;
          end
          8'h10: begin
            thr_q  <= req_wdata;
            bcnt_q <= req_wdata + 32'd1;
          end
          8'h18: stat_q <= stat_q & ~req_wdata;
          8'h1C: ien_q  <= req_wdata & STAT_MASK;
          8'h24: fthr_q <= req_wdata[15:8];
          default: ;
        endcase
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH)); // R4
  AST_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> occ_q <= $past(occ_q)); // R4
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && req_addr == 8'h00 && req_wdata[0] && !ctrl_q[0] |=> bcnt_q == WARM); // R3
  AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && req_addr == 8'h10 |=> thr_q == $past(req_wdata) && bcnt_q == $past(req_wdata) + 32'd1); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && req_addr == 8'h18 |=> (stat_q & $past(req_wdata)) == 32'h0); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && req_addr == 8'h04 && req_wdata[0] |=> occ_q == '0 && stat_q == STARTUP && ctrl_q == '0); // R10
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R2
endmodule

// File: tb/sim_rng_fifo_periph.sv
module sim_rng_fifo_periph;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SEED = 32'hACE1_2468;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, irq;
  logic [31:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_fifo_periph u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl, m_bc, m_thr, m_st, m_ie, m_lfsr;
  logic [7:0]  m_fthr;
  logic [7:0]  mq[$];

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic model_clear();
    m_ctrl = 0; m_bc = 0; m_thr = 0; m_ie = 0; m_st = 32'h0002_0000; m_fthr = 0;
    mq.delete();
  endtask

  task automatic model_step(input bit v, input bit we, input logic [7:0] a,
                            input logic [31:0] wd, output logic [31:0] exp);
    bit wr, rd, push;
    int n;
    wr = v && we;
    rd = v && !we;
    exp = 0;
    n = (mq.size() < 4) ? mq.size() : 4;
    if (rd) begin
      case (a)
        8'h00: exp = m_ctrl;
        8'h0C: exp = m_bc;
        8'h10: exp = m_thr;
        8'h18: exp = m_st;
        8'h1C: exp = m_ie;
        8'h20: for (int i = 0; i < n; i++) exp[8*i +: 8] = mq[i];
        8'h24: exp = {16'h0, m_fthr, 8'(mq.size() >> 2)};
        default: exp = 0;
      endcase
    end
    push = m_ctrl[0] && !wr && mq.size() < 128 && (({1'b0, m_bc} + 33'd8) < {1'b0, m_thr});
    if (rd && a == 8'h20) for (int i = 0; i < n; i++) void'(mq.pop_front());
    if (push) begin
      mq.push_back(m_lfsr[7:0]);
      m_lfsr = lfsr_step(m_lfsr);
      m_bc = m_bc + 8;
      if (mq.size() > int'(m_fthr)) m_st[0] = 1'b1;
    end
    if (wr) begin
      case (a)
        8'h00: begin
          if (!m_ctrl[0] && wd[0]) m_bc = 17;
          m_ctrl = wd & 32'h001F_E001;
        end
        8'h04: if (wd[0]) model_clear();
        8'h10: begin m_thr = wd; m_bc = wd + 1; end
        8'h18: m_st = m_st & ~wd;
        8'h1C: m_ie = wd & 32'h4002_0021;
        8'h24: m_fthr = wd[15:8];
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit v, input bit we, input logic [7:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    req_valid = v; req_write = we; req_addr = a; req_wdata = wd;
    model_step(v, we, a, wd, exp);
    @(negedge clk);
    if (v && !we) chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    chk(irq == |(m_st & m_ie), "R9 irq", {31'b0, irq}, {31'b0, |(m_st & m_ie)});
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    op(1, 1, a, d, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    op(1, 0, a, 32'h0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 8'h0, 32'h0, "idle");
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R3";
      8'h0C: return "R4";
      8'h10: return "R5";
      8'h18: return "R8";
      8'h1C: return "R9";
      8'h20: return "R7";
      8'h24: return "R6";
      default: return "R2";
    endcase
  endfunction

  initial begin
    logic [7:0] addrs [13];
    int unsigned s;
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h3C, 8'h21};
    s = $urandom(32'd5);
    model_clear();
    m_lfsr = SEED;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h18, "R1"); rd(8'h00, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1"); rd(8'h1C, "R1"); rd(8'h24, "R1");
    rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h14, "R2"); rd(8'h30, "R2"); rd(8'h01, "R2");
    wr(8'h30, 32'hFFFF_FFFF, "R2"); wr(8'h02, 32'hFFFF_FFFF, "R2"); wr(8'h0C, 32'h1234, "R2");
    rd(8'h00, "R2"); rd(8'h0C, "R2");
    wr(8'h10, 32'd1000, "R5"); rd(8'h0C, "R5"); rd(8'h10, "R5");
    wr(8'h00, 32'hFFFF_FFFF, "R3"); rd(8'h00, "R3"); rd(8'h0C, "R3");
    idle(20); rd(8'h0C, "R4"); rd(8'h24, "R6");
    wr(8'h24, 32'hFFFF_28AA, "R6"); rd(8'h24, "R6");
    wr(8'h1C, 32'hFFFF_FFFF, "R9"); wr(8'h18, 32'hFFFF_FFFF, "R9"); rd(8'h18, "R9");
    idle(40); rd(8'h18, "R8");
    wr(8'h00, 32'h0, "R4"); idle(10); rd(8'h24, "R4"); rd(8'h0C, "R4");
    for (int i = 0; i < 25; i++) rd(8'h20, "R7");
    rd(8'h24, "R7");
    wr(8'h10, 32'hFFFF_FFFF, "R5"); wr(8'h00, 32'h1, "R4");
    idle(140); rd(8'h24, "R4 full");
    wr(8'h04, 32'h0, "R10"); rd(8'h24, "R10");
    wr(8'h04, 32'h1, "R10"); rd(8'h18, "R10"); rd(8'h24, "R10"); rd(8'h00, "R10");
    wr(8'h10, 32'd60, "R4"); wr(8'h00, 32'h1, "R4"); idle(10);
    rd(8'h0C, "R4 gate"); rd(8'h24, "R4 gate");
    wr(8'h08, 32'hFFFF_FFFF, "R10"); rd(8'h0C, "R10"); rd(8'h24, "R10");
    rd(8'h20, "R7"); rd(8'h20, "R7 partial"); rd(8'h20, "R7 empty");
    wr(8'h10, 32'hFFFF_0000, "R11"); idle(6);
    for (int i = 0; i < 6; i++) begin rd(8'h20, "R11"); rd(8'h24, "R11"); end
    for (int k = 0; k < 4000; k++) begin
      bit v, we;
      logic [7:0] a;
      logic [31:0] d;
      v = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      a = addrs[$urandom % 13];
      d = $urandom;
      if (a == 8'h04) d[0] = ($urandom % 8) == 0;
      if (a == 8'h00) d[0] = ($urandom % 4) != 0;
      if (a == 8'h10) d = ($urandom % 2) ? 32'hFFFF_FF00 : ($urandom % 2000);
      op(v, we, a, d, tag_of(a));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule